// File: doc/BRIEF.md
# Read-Once Buffered Input Port

This block sits between a producer of 8-bit codes (for example a keyboard receiver) and the I/O read side of a small CPU bus. Each code that arrives with a one-cycle valid strobe is appended to a circular buffer. The oldest buffered code is moved into a single port register. The CPU sees that register when it reads one decoded I/O address.

When a CPU read of the port ends, the port register is cleared to zero. Only after that clear is the next buffered code moved into it. A read therefore never returns the same code twice, and a value of zero always means that nothing new is waiting. No separate status register is needed. The end of a read is found from the falling edge of the decoded select, so even a very short strobe is counted once.

The CPU strobes are active low and are taken to be synchronous to `clk`. The port is placed on the bus only during a matching read cycle. If a code arrives while the buffer is full, that code is dropped and a sticky overflow flag is set.

Top module: `rdonce_port`

## Requirements
- R1: After reset `dout` is 0, `dout_oe` is 0, `overflow` is 0 and the buffer holds no codes, so the first read returns 0.
- R2: The port answers only when `cpu_addr` equals PORT_ADDR (default 8'h08), `cpu_iorq_n` is 0 and `cpu_rd_n` is 0. At any other time `dout_oe` is 0 and `dout` is 0, and no buffered code is consumed.
- R3: A code accepted at a clock edge while the port is empty can be read by a read cycle that begins after the next clock edge.
- R4: When a read cycle ends, the port value becomes 0. An immediate second read returns 0 if nothing else is buffered.
- R5: Codes that arrive while the port holds an unread value are queued. They are delivered in arrival order, one code per read.
- R6: The port value does not change during a read cycle, even if codes arrive during that read. A code that arrives during a read that returns 0 is delivered by the next read.
- R7: Both buffer pointers wrap to slot 0 after slot DEPTH-1 (default DEPTH 16). A sequence of codes that is longer than DEPTH is delivered intact.
- R8: Capacity is DEPTH buffered codes plus the one held in the port. A code that arrives when the buffer is full is dropped and sets `overflow`. `overflow` stays 1 until reset.
- R9: If a code arrives in the same cycle that a read ends, the code is neither lost nor duplicated, whether or not other codes are already buffered.
- R10: A read select that is active for a single clock cycle consumes exactly one code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | CODE_W | Incoming code |
| code_valid | input | 1 | One-cycle strobe qualifying `code_in` |
| cpu_addr | input | ADDR_W | CPU I/O address |
| cpu_iorq_n | input | 1 | I/O request, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| dout | output | CODE_W | Port value during a matching read, else 0 |
| dout_oe | output | 1 | Drive enable for the data bus |
| overflow | output | 1 | Sticky flag: a code was dropped |

## Verification
Two events can fall in the same cycle: the end of a CPU read, which clears the port, and the arrival of a new code. The bench forces this collision by deasserting the read strobe and raising the valid strobe on the same clock edge. It does this once with an empty buffer and once with a code already queued. The collision is judged by the codes that later reads return: every code must come back exactly once, in arrival order, and the last read must return 0. A second collision, a code arriving in the middle of a long read, is judged by sampling the port on every cycle of that read.

// File: rtl/rdonce_pkg.sv
package rdonce_pkg;

    parameter int unsigned DEF_CODE_W    = 8;
    parameter int unsigned DEF_ADDR_W    = 8;
    parameter int unsigned DEF_DEPTH     = 16;
    parameter int unsigned DEF_PORT_ADDR = 8;

    // Bus events derived from the CPU strobes
    typedef struct packed {
        logic sel;     // matching read cycle in progress
        logic rd_end;  // matching read cycle just ended
    } rd_evt_t;

    typedef enum logic {
        PORT_EMPTY = 1'b0,
        PORT_HELD  = 1'b1
    } port_state_t;

    function automatic logic ring_is_full(input logic msb_w, input logic msb_r,
                                          input logic low_eq);
        return (msb_w != msb_r) && low_eq;
    endfunction

endpackage

// File: rtl/rdonce_decode.sv
module rdonce_decode
    import rdonce_pkg::*;
#(
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned PORT_ADDR = DEF_PORT_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              iorq_n,
    input  logic              rd_n,
    output rd_evt_t           evt
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PORT_ADDR);

    logic sel_now;
    logic sel_q;

    assign sel_now = (addr == MATCH) && !iorq_n && !rd_n;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= sel_now;
    end

    assign evt.sel    = sel_now;
    assign evt.rd_end = sel_q && !sel_now;

endmodule

// File: rtl/code_ring.sv
module code_ring
    import rdonce_pkg::*;
#(
    parameter int unsigned CODE_W = DEF_CODE_W,
    parameter int unsigned DEPTH  = DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [CODE_W-1:0] din,
    input  logic              pop,
    output logic [CODE_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic              overflow
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CODE_W-1:0] mem [DEPTH];
    logic [PW:0]       wr_ptr;
    logic [PW:0]       rd_ptr;
    logic              accept;
    logic              drop;

    assign empty  = (wr_ptr == rd_ptr);
    assign full   = ring_is_full(wr_ptr[PW], rd_ptr[PW], wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);
    assign accept = push && (!full || pop);
    assign drop   = push && !accept;
    assign head   = mem[rd_ptr[PW-1:0]];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr[PW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (pop)    rd_ptr <= rd_ptr + 1'b1;
            if (drop)   overflow <= 1'b1;
        end
    end

    // R7
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R7
    empty_full_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    // R8
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

endmodule

// File: rtl/port_holder.sv
module port_holder
    import rdonce_pkg::*;
#(
    parameter int unsigned CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_evt_t           evt,
    input  logic              ring_empty,
    input  logic [CODE_W-1:0] ring_head,
    output logic              pop,
    output logic [CODE_W-1:0] value
);
    port_state_t state;

    // Refill only after the clear, never during a read
    assign pop = (state == PORT_EMPTY) && !ring_empty && !evt.sel && !evt.rd_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PORT_EMPTY;
            value <= '0;
        end else if (evt.rd_end) begin
            state <= PORT_EMPTY;
            value <= '0;
        end else if (pop) begin
            state <= PORT_HELD;
            value <= ring_head;
        end
    end

    // R4
    clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        evt.rd_end |=> (value == '0) && (state == PORT_EMPTY));

    // R6
    stable_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        evt.sel |=> $stable(value));

    // R5
    held_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PORT_HELD) && !evt.rd_end |=> $stable(value));

endmodule

// File: rtl/rdonce_port.sv
module rdonce_port
    import rdonce_pkg::*;
#(
    parameter int unsigned CODE_W    = DEF_CODE_W,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned DEPTH     = DEF_DEPTH,
    parameter int unsigned PORT_ADDR = DEF_PORT_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_iorq_n,
    input  logic              cpu_rd_n,
    output logic [CODE_W-1:0] dout,
    output logic              dout_oe,
    output logic              overflow
);
    rd_evt_t           evt;
    logic              pop;
    logic              ring_empty;
    logic              ring_full;
    logic [CODE_W-1:0] ring_head;
    logic [CODE_W-1:0] port_val;

    rdonce_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_decode (
        .clk(clk), .rst(rst), .addr(cpu_addr), .iorq_n(cpu_iorq_n),
        .rd_n(cpu_rd_n), .evt(evt)
    );

    code_ring #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst(rst), .push(code_valid), .din(code_in), .pop(pop),
        .head(ring_head), .empty(ring_empty), .full(ring_full),
        .overflow(overflow)
    );

    port_holder #(.CODE_W(CODE_W)) u_holder (
        .clk(clk), .rst(rst), .evt(evt), .ring_empty(ring_empty),
        .ring_head(ring_head), .pop(pop), .value(port_val)
    );

    assign dout_oe = evt.sel;
    assign dout    = evt.sel ? port_val : '0;

    // R2
    oe_decode_chk: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> (cpu_addr == ADDR_W'(PORT_ADDR)) && !cpu_iorq_n && !cpu_rd_n);

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ring_full && code_valid && !pop |=> overflow);

endmodule

// File: tb/rdonce_port_bench.sv
module rdonce_port_bench;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] code_in = '0;
    logic       code_valid = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic       cpu_iorq_n = 1'b1;
    logic       cpu_rd_n = 1'b1;
    logic [7:0] dout;
    logic       dout_oe;
    logic       overflow;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rdonce_port u_rdonce_port (
        .clk(clk), .rst(rst), .code_in(code_in), .code_valid(code_valid),
        .cpu_addr(cpu_addr), .cpu_iorq_n(cpu_iorq_n), .cpu_rd_n(cpu_rd_n),
        .dout(dout), .dout_oe(dout_oe), .overflow(overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] c);
        @(negedge clk); code_in = c; code_valid = 1'b1;
        @(negedge clk); code_valid = 1'b0;
    endtask

    // Read lasting len cycles; value sampled on the first cycle, checked stable
    task automatic do_read(input int len, input string req, input int exp);
        logic [7:0] v;
        @(negedge clk);
        cpu_addr = 8'h08; cpu_iorq_n = 1'b0; cpu_rd_n = 1'b0;
        #1 v = dout;
        chk(req, v, exp);
        for (int i = 1; i < len; i++) begin
            @(negedge clk); #1;
            if (dout !== v || !dout_oe) chk({req, " stable"}, dout, v);
        end
        @(negedge clk); cpu_rd_n = 1'b1; cpu_iorq_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Read whose end coincides with a new code
    task automatic read_push_end(input logic [7:0] c, input string req, input int exp);
        @(negedge clk);
        cpu_addr = 8'h08; cpu_iorq_n = 1'b0; cpu_rd_n = 1'b0;
        #1 chk(req, dout, exp);
        @(negedge clk);
        cpu_rd_n = 1'b1; cpu_iorq_n = 1'b1; code_in = c; code_valid = 1'b1;
        @(negedge clk); code_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 dout", dout, 0);
        chk("R1 oe", dout_oe, 0);
        chk("R1 overflow", overflow, 0);
        do_read(2, "R1 first read", 0);
    endtask

    task automatic t_decode();
        push(8'h5A);
        @(negedge clk);
        cpu_addr = 8'h09; cpu_iorq_n = 1'b0; cpu_rd_n = 1'b0;
        #1 chk("R2 wrong addr oe", dout_oe, 0); chk("R2 wrong addr dout", dout, 0);
        @(negedge clk); cpu_addr = 8'h88;
        #1 chk("R2 addr 88 oe", dout_oe, 0);
        @(negedge clk); cpu_addr = 8'h08; cpu_iorq_n = 1'b1;
        #1 chk("R2 no iorq oe", dout_oe, 0);
        @(negedge clk); cpu_iorq_n = 1'b0; cpu_rd_n = 1'b1;
        #1 chk("R2 no rd oe", dout_oe, 0); chk("R2 no rd dout", dout, 0);
        @(negedge clk); cpu_iorq_n = 1'b1;
        repeat (2) @(negedge clk);
        do_read(2, "R2 code kept", 8'h5A);
        do_read(2, "R4 second read", 0);
    endtask

    task automatic t_latency();
        // valid at edge k, refill at k+1, read begins after k+1
        @(negedge clk); code_in = 8'h31; code_valid = 1'b1;
        @(negedge clk); code_valid = 1'b0;
        @(negedge clk);
        cpu_addr = 8'h08; cpu_iorq_n = 1'b0; cpu_rd_n = 1'b0;
        #1 chk("R3 latency", dout, 8'h31); chk("R3 oe", dout_oe, 1);
        @(negedge clk); cpu_rd_n = 1'b1; cpu_iorq_n = 1'b1;
        repeat (3) @(negedge clk);
        do_read(1, "R4 cleared", 0);
    endtask

    task automatic t_order();
        push(8'h11); push(8'h22); push(8'h33);
        do_read(3, "R5 first", 8'h11);
        do_read(3, "R5 second", 8'h22);
        do_read(3, "R5 third", 8'h33);
        do_read(3, "R5 drained", 0);
    endtask

    task automatic t_mid_read();
        // Code arrives during a read that returns 0
        @(negedge clk);
        cpu_addr = 8'h08; cpu_iorq_n = 1'b0; cpu_rd_n = 1'b0;
        code_in = 8'h44; code_valid = 1'b1;
        #1 chk("R6 zero read", dout, 0);
        @(negedge clk); code_valid = 1'b0;
        #1 chk("R6 zero held", dout, 0);
        @(negedge clk); #1 chk("R6 zero held late", dout, 0);
        @(negedge clk); cpu_rd_n = 1'b1; cpu_iorq_n = 1'b1;
        repeat (3) @(negedge clk);
        do_read(2, "R6 code after zero read", 8'h44);
        // Code arrives during a read of a held value
        push(8'h55);
        @(negedge clk);
        cpu_addr = 8'h08; cpu_iorq_n = 1'b0; cpu_rd_n = 1'b0;
        code_in = 8'h66; code_valid = 1'b1;
        #1 chk("R6 held read", dout, 8'h55);
        @(negedge clk); code_valid = 1'b0;
        #1 chk("R6 held stable", dout, 8'h55);
        @(negedge clk); cpu_rd_n = 1'b1; cpu_iorq_n = 1'b1;
        repeat (3) @(negedge clk);
        do_read(2, "R6 queued", 8'h66);
        do_read(2, "R6 drained", 0);
    endtask

    task automatic t_collide();
        push(8'hA1);
        read_push_end(8'hB2, "R9 empty ring read", 8'hA1);
        do_read(2, "R9 new code", 8'hB2);
        do_read(2, "R9 no dup", 0);
        push(8'hC3); push(8'hD4);
        read_push_end(8'hE5, "R9 busy ring read", 8'hC3);
        do_read(2, "R9 busy second", 8'hD4);
        do_read(2, "R9 busy third", 8'hE5);
        do_read(2, "R9 busy drained", 0);
    endtask

    task automatic t_short();
        push(8'h71); push(8'h72);
        do_read(1, "R10 one-cycle first", 8'h71);
        do_read(1, "R10 one-cycle second", 8'h72);
        do_read(1, "R10 one-cycle empty", 0);
    endtask

    task automatic t_overflow();
        chk("R8 no overflow yet", overflow, 0);
        @(negedge clk);
        for (int i = 0; i < DEPTH + 2; i++) begin
            code_in = 8'(8'h20 + i); code_valid = 1'b1;
            @(negedge clk);
        end
        code_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 overflow set", overflow, 1);
        for (int i = 0; i < DEPTH + 1; i++)
            do_read(1, "R7 wrap order", 8'h20 + i);
        do_read(1, "R8 dropped code absent", 0);
        chk("R8 overflow sticky", overflow, 1);
        do_reset();
        chk("R1 overflow after reset", overflow, 0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_decode();
        t_latency();
        t_order();
        t_mid_read();
        t_collide();
        t_short();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule